// File: doc/BRIEF.md
# Status Register and Write-Permission Guard for a Serial Memory

This block keeps the status byte of a serial memory that sits behind an SPI front end. It also decides, cycle by cycle, whether the current write request may go ahead. The front end decodes the opcodes and presents them as single-cycle strobes:

- write-latch set
- write-latch clear, which also clears the user flag
- flag set
- status-write request, with its data byte
- array-write request, with the target address
- end of the self-timed write cycle

The block returns the status byte and two combinational grants: one for array writes and one for status writes.

The protection bits and the lock-enable bit are nonvolatile in the memory. Here they are ordinary flops that come out of reset with parameter values. A granted request starts an internal write cycle, and the busy bit stays set until the cycle-done strobe. A granted status write has its data captured at grant time and committed when the cycle ends. Because of this, a protect pin that falls during that cycle cannot abort it.

Top module: `spi_status_guard`

## Requirements
- R1: After reset the status byte is {WPEN_INIT, 0, 0, 0, BL_INIT[1], BL_INIT[0], 0, 0}, which is 0x00 with default parameters.
- R2: The status byte carries the lock-enable bit at bit 7, the flag at bit 6, zeros at bits 5 and 4, the protection code at bits 3:2, the write latch at bit 1 and busy at bit 0.
- R3: Write-latch set raises bit 1 and write-latch clear drops it. The end of any write cycle (cyc_done while busy) also drops it.
- R4: Flag set raises bit 6, and write-latch clear drops it. A status write never changes bit 6.
- R5: While bit 1 is 0, neither grant is ever given.
- R6: Protection code 00 guards nothing. Code 01 guards the top quarter of the address space (0x600-0x7FF for 11 address bits), code 10 the top half (0x400-0x7FF), and code 11 every address. A request to a guarded address gets no array grant.
- R7: With bit 1 set, a status write is refused when bit 7 is 1 and wp_n is low. In every other such case it is granted.
- R8: A completed status write stores data bits 7, 3 and 2 only. Data bits 6, 5, 4, 1 and 0 have no effect.
- R9: Bit 0 reads 1 from the cycle after a grant until cyc_done. During that time both grants are held at 0, and the set, clear and flag strobes have no effect.
- R10: Lowering wp_n during a running status write does not cancel it. Once it has committed lock-enable = 1, later status writes are refused.
- R11: A refused array write leaves bit 1 unchanged and does not set bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wel_set | input | 1 | Strobe: set the write latch |
| cmd_wel_clr | input | 1 | Strobe: clear the write latch and the flag |
| cmd_flag_set | input | 1 | Strobe: set the user flag |
| st_wr_req | input | 1 | Status-write request |
| st_wr_data | input | 8 | Data byte of the status write |
| arr_wr_req | input | 1 | Array-write request |
| arr_addr | input | ADDR_W | Target array address |
| cyc_done | input | 1 | End of the self-timed write cycle |
| wp_n | input | 1 | Write-protect pin, active low |
| status | output | 8 | Status byte |
| arr_grant | output | 1 | Array write permitted (combinational) |
| st_grant | output | 1 | Status write permitted (combinational) |

## Verification
Most wrong internal states show up on the `status` port one cycle after the strobe that should have changed them.

A latch or a protection code that holds the wrong value shows up in the same cycle as the next request. The grant that follows from it is computed combinationally from the registered state, so it comes out wrong at once.

A status write that was captured but lost, or committed with the wrong bits, only shows after `cyc_done`. The bench therefore reads the status byte right after every completion. It then issues a fresh request, so that the committed lock state is exercised through the grants.

// File: rtl/spg_pkg.sv
package spg_pkg;

    localparam int STATUS_W = 8;

    typedef struct packed {
        logic       wpen;      // lock enable (nonvolatile model)
        logic       flag;      // volatile user flag
        logic [1:0] bl;        // protection code (nonvolatile model)
        logic       wel;       // write latch
        logic       wip;       // internal write cycle running
        logic       st_pend;   // running cycle is a status write
        logic       wpen_new;  // captured lock enable
        logic [1:0] bl_new;    // captured protection code
    } guard_state_t;

    function automatic logic [STATUS_W-1:0] pack_status(guard_state_t s);
        return {s.wpen, s.flag, 2'b00, s.bl, s.wel, s.wip};
    endfunction

endpackage

// File: rtl/spg_lock_map.sv
module spg_lock_map #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        bl,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);
    localparam int TOP = ADDR_W - 1;

    always_comb begin
        case (bl)
            2'b00:   guarded = 1'b0;
            2'b01:   guarded = addr[TOP] & addr[TOP-1];
            2'b10:   guarded = addr[TOP];
            default: guarded = 1'b1;
        endcase
    end
endmodule

// File: rtl/spg_permit.sv
module spg_permit (
    input  logic wel,
    input  logic wip,
    input  logic wpen,
    input  logic wp_n,
    input  logic guarded,
    input  logic arr_req,
    input  logic st_req,
    output logic arr_ok,
    output logic st_ok
);
    logic ready;
    logic pin_lock;

    always_comb begin
        ready    = wel & ~wip;
        pin_lock = wpen & ~wp_n;
        arr_ok   = arr_req & ready & ~guarded;
        st_ok    = st_req & ready & ~pin_lock;
    end
endmodule

// File: rtl/spi_status_guard.sv
module spi_status_guard
    import spg_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter logic       WPEN_INIT = 1'b0,
    parameter logic [1:0] BL_INIT   = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wel_set,
    input  logic              cmd_wel_clr,
    input  logic              cmd_flag_set,
    input  logic              st_wr_req,
    input  logic [7:0]        st_wr_data,
    input  logic              arr_wr_req,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              cyc_done,
    input  logic              wp_n,
    output logic [7:0]        status,
    output logic              arr_grant,
    output logic              st_grant
);
    localparam int WPEN_BIT = 7;
    localparam int BL_HI    = 3;
    localparam int BL_LO    = 2;

    guard_state_t st_d, st_q;
    logic         guarded;

    spg_lock_map #(.ADDR_W(ADDR_W)) u_map (
        .bl      (st_q.bl),
        .addr    (arr_addr),
        .guarded (guarded)
    );

    spg_permit u_permit (
        .wel     (st_q.wel),
        .wip     (st_q.wip),
        .wpen    (st_q.wpen),
        .wp_n    (wp_n),
        .guarded (guarded),
        .arr_req (arr_wr_req),
        .st_req  (st_wr_req),
        .arr_ok  (arr_grant),
        .st_ok   (st_grant)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.wip) begin
            if (cmd_wel_set)  st_d.wel  = 1'b1;
            if (cmd_flag_set) st_d.flag = 1'b1;
            if (cmd_wel_clr) begin
                st_d.wel  = 1'b0;
                st_d.flag = 1'b0;
            end
            if (arr_grant) st_d.wip = 1'b1;
            if (st_grant) begin
                st_d.wip      = 1'b1;
                st_d.st_pend  = 1'b1;
                st_d.wpen_new = st_wr_data[WPEN_BIT];
                st_d.bl_new   = st_wr_data[BL_HI:BL_LO];
            end
        end else if (cyc_done) begin
            st_d.wip = 1'b0;
            st_d.wel = 1'b0;
            if (st_q.st_pend) begin
                st_d.wpen    = st_q.wpen_new;
                st_d.bl      = st_q.bl_new;
                st_d.st_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.wpen     <= WPEN_INIT;
            st_q.bl       <= BL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = pack_status(st_q);

endmodule

// File: rtl/spg_checker.sv
module spg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wel_set,
    input logic       cmd_wel_clr,
    input logic       arr_wr_req,
    input logic       cyc_done,
    input logic       wp_n,
    input logic [7:0] status,
    input logic       arr_grant,
    input logic       st_grant
);
    a_r5_no_grant_without_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || st_grant) |-> status[1]);

    a_r9_busy_blocks_grants: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (!arr_grant && !st_grant));

    a_r9_grant_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || st_grant) |=> status[0]);

    a_r3_done_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && status[0]) |=> (!status[1] && !status[0]));

    a_r7_pin_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        st_grant |-> !(status[7] && !wp_n));

    a_r6_full_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> (status[3:2] != 2'b11));

    a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:4] == 2'b00);

    a_r11_refusal_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_req && !arr_grant && !status[0] && !cmd_wel_set && !cmd_wel_clr)
        |=> ($stable(status[1]) && !status[0]));
endmodule

bind spi_status_guard spg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wel_set (cmd_wel_set),
    .cmd_wel_clr (cmd_wel_clr),
    .arr_wr_req  (arr_wr_req),
    .cyc_done    (cyc_done),
    .wp_n        (wp_n),
    .status      (status),
    .arr_grant   (arr_grant),
    .st_grant    (st_grant)
);

// File: tb/sim_spi_status_guard.sv
`timescale 1ns/1ps
module sim_spi_status_guard;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_wel_set = 1'b0, cmd_wel_clr = 1'b0, cmd_flag_set = 1'b0;
    logic              st_wr_req = 1'b0, arr_wr_req = 1'b0, cyc_done = 1'b0;
    logic              wp_n = 1'b1;
    logic [7:0]        st_wr_data = '0;
    logic [ADDR_W-1:0] arr_addr = '0;
    logic [7:0]        status;
    logic              arr_grant, st_grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_status_guard #(.ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wel_set(cmd_wel_set), .cmd_wel_clr(cmd_wel_clr),
        .cmd_flag_set(cmd_flag_set), .st_wr_req(st_wr_req), .st_wr_data(st_wr_data),
        .arr_wr_req(arr_wr_req), .arr_addr(arr_addr), .cyc_done(cyc_done), .wp_n(wp_n),
        .status(status), .arr_grant(arr_grant), .st_grant(st_grant)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // advance one clock; inputs are driven and outputs sampled at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wel_set();
        cmd_wel_set = 1'b1; tick(); cmd_wel_set = 1'b0;
    endtask

    task automatic wel_clr();
        cmd_wel_clr = 1'b1; tick(); cmd_wel_clr = 1'b0;
    endtask

    // full status write with the pin high, then completion
    task automatic write_status(logic [7:0] d);
        wp_n = 1'b1;
        wel_set();
        st_wr_req = 1'b1; st_wr_data = d;
        tick();
        st_wr_req = 1'b0;
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
    endtask

    task automatic probe_addr(logic [ADDR_W-1:0] a, logic exp, string req);
        arr_wr_req = 1'b1; arr_addr = a;
        #1;
        check(req, arr_grant, exp);
        arr_wr_req = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset status", status, 8'h00);
        check("R1 no grants", {arr_grant, st_grant}, 2'b00);
    endtask

    task automatic t_wel();
        wel_set();
        check("R3 set latch", status, 8'h02);
        wel_clr();
        check("R3 clear latch", status, 8'h00);
    endtask

    task automatic t_flag();
        cmd_flag_set = 1'b1; tick(); cmd_flag_set = 1'b0;
        check("R4 flag set", status, 8'h40);
        write_status(8'h00);
        check("R4 status write keeps flag", status, 8'h40);
        wel_set();
        wel_clr();
        check("R4 clear drops flag and latch", status, 8'h00);
    endtask

    task automatic t_nowel();
        arr_wr_req = 1'b1; arr_addr = '0; st_wr_req = 1'b1;
        #1;
        check("R5 no grants without latch", {arr_grant, st_grant}, 2'b00);
        tick();
        arr_wr_req = 1'b0; st_wr_req = 1'b0;
        check("R5 no cycle started", status, 8'h00);
    endtask

    task automatic t_status_write();
        wel_set();
        st_wr_req = 1'b1; st_wr_data = 8'hFF;
        #1;
        check("R7 grant with lock off", st_grant, 1'b1);
        tick();
        st_wr_req = 1'b0;
        check("R9 busy, latch held", status, 8'h03);
        arr_wr_req = 1'b1; st_wr_req = 1'b1; arr_addr = '0;
        #1;
        check("R9 no grants while busy", {arr_grant, st_grant}, 2'b00);
        arr_wr_req = 1'b0; st_wr_req = 1'b0;
        cmd_flag_set = 1'b1; cmd_wel_clr = 1'b1;
        tick();
        cmd_flag_set = 1'b0; cmd_wel_clr = 1'b0;
        check("R9 strobes ignored while busy", status, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        check("R8 only bits 7,3,2 stored (R2 layout)", status, 8'h8C);
        write_status(8'h73);
        check("R8 ignored data bits", status, 8'h00);
    endtask

    task automatic t_lock_map();
        write_status(8'h04);
        wel_set();
        probe_addr(11'h5FF, 1'b1, "R6 code01 below quarter");
        probe_addr(11'h600, 1'b0, "R6 code01 quarter start");
        probe_addr(11'h7FF, 1'b0, "R6 code01 top");
        arr_wr_req = 1'b1; arr_addr = 11'h700;
        tick();
        arr_wr_req = 1'b0;
        check("R11 refused write keeps latch", status, 8'h06);
        write_status(8'h08);
        wel_set();
        probe_addr(11'h3FF, 1'b1, "R6 code10 below half");
        probe_addr(11'h400, 1'b0, "R6 code10 half start");
        write_status(8'h0C);
        wel_set();
        probe_addr(11'h000, 1'b0, "R6 code11 bottom");
        write_status(8'h00);
        wel_set();
        probe_addr(11'h7FF, 1'b1, "R6 code00 top");
        arr_wr_req = 1'b1; arr_addr = 11'h7FF;
        tick();
        arr_wr_req = 1'b0;
        check("R9 array cycle busy", status, 8'h03);
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        check("R3 done clears latch", status, 8'h00);
    endtask

    task automatic t_pin();
        wp_n = 1'b0;
        wel_set();
        st_wr_req = 1'b1;
        #1;
        check("R7 lock off, pin low grants", st_grant, 1'b1);
        st_wr_req = 1'b0;
        write_status(8'h80);
        wp_n = 1'b0;
        wel_set();
        st_wr_req = 1'b1; arr_wr_req = 1'b1; arr_addr = 11'h123;
        #1;
        check("R7 lock on, pin low refuses", st_grant, 1'b0);
        check("R7 array still writable", arr_grant, 1'b1);
        arr_wr_req = 1'b0;
        wp_n = 1'b1;
        #1;
        check("R7 lock on, pin high grants", st_grant, 1'b1);
        st_wr_req = 1'b0;
        write_status(8'h00);
        check("R7 lock cleared", status, 8'h00);
    endtask

    task automatic t_abort();
        wp_n = 1'b1;
        wel_set();
        st_wr_req = 1'b1; st_wr_data = 8'h80;
        tick();
        st_wr_req = 1'b0;
        wp_n = 1'b0;
        tick();
        cyc_done = 1'b1; tick(); cyc_done = 1'b0;
        check("R10 write not cancelled", status, 8'h80);
        wel_set();
        st_wr_req = 1'b1;
        #1;
        check("R10 later write refused", st_grant, 1'b0);
        st_wr_req = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wel();
        t_flag();
        t_nowel();
        t_status_write();
        t_lock_map();
        t_pin();
        t_abort();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule